// File: doc/BRIEF.md
# Colour Channel Mask Analyzer

This block takes the raw bit masks of the red, green and blue fields of a packed pixel, plus the pixel depth in bits, and works out how each field sits in the word. It first limits each mask to the bits that the depth allows. It then scans the limited mask from both ends. From the scan it reports three values for each channel. The up-shift is the position of the lowest set bit. The down-shift is the amount an 8-bit component loses when it is packed into the field. The bit count is the index of the highest set bit plus one.

A single scanner is shared by the three channels. After a start request the block takes one clock per channel, in the order green, blue, red. It then pulses done for one cycle. If the depth is not supported, the block pulses done and fail together on the cycle after the start and leaves every result output unchanged. Results hold their values until the next successful run.

Top module: `chan_mask_analyzer`

## Requirements
- R1: After reset, every result output is 0, and busy_o, done_o and fail_o are low.
- R2: The depth selects a premask through depth_i divided by 8 (integer division). A quotient of 2 (depths 16 to 23) gives 0x0000FFFF. A quotient of 3 or 4 (depths 24 to 39) gives 0x00FFFFFF. The stored qualified mask of each channel is its raw mask ANDed with that premask.
- R3: Any other quotient is unsupported. On the cycle after start, done_o and fail_o are both high, busy_o stays low, and no result output changes.
- R4: up_o for a channel equals the index of the lowest set bit of its qualified mask.
- R5: down_o for a channel equals 8 minus the field width, where the width is (highest set index - lowest set index + 1). It is 0 when the width is 8 or more.
- R6: bits_o for a channel equals the highest set index of its qualified mask plus one.
- R7: A qualified mask of zero sets that channel's zero_o bit, and its up_o, down_o and bits_o are all 0. A nonzero qualified mask clears the zero_o bit.
- R8: The three channels are written on consecutive clocks in the order green, blue, red. The first write happens on the edge after the edge that accepts start.
- R9: busy_o is high from the accepting edge until the red channel is written. done_o is high for exactly one cycle, on the edge that writes red, with fail_o low.
- R10: A start_i request made while busy_o is high is ignored. The raw masks and depth in use for that run do not change.
- R11: For a 16-bit 5:6:5 layout (red 0xF800, green 0x07E0, blue 0x001F), the up-shifts for red, green and blue are 11, 5 and 0, and the down-shifts are 3, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to analyze the presented masks |
| depth_i | input | 6 | Pixel depth in bits |
| mask_r_i | input | 32 | Raw red mask |
| mask_g_i | input | 32 | Raw green mask |
| mask_b_i | input | 32 | Raw blue mask |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Set together with done_o when the depth is unsupported |
| qmask_o | output | 96 | Qualified masks; red at [31:0], green at [63:32], blue at [95:64] |
| up_o | output | 15 | Up-shifts, 5 bits per channel, same channel order |
| down_o | output | 9 | Down-shifts, 3 bits per channel |
| bits_o | output | 18 | Bit counts, 6 bits per channel |
| zero_o | output | 3 | Zero-mask flags; bit 0 red, bit 1 green, bit 2 blue |

## Verification
The cases that are hardest to reach from the ports are those in the middle of a run: a second start that arrives while busy, and a partly written result set in which green is new while blue and red still hold the previous run. To reach them, the bench re-requests start with different masks and an illegal depth during the first busy cycle. It also samples the outputs after each intermediate edge and compares them with per-channel old and new expectations. Every contiguous field from bit 0 to bit 31 is applied at each end of the word, and all 64 depth values are swept. Together these cover the width clamp, the premask edges and the failure path, in which the outputs must stay unchanged.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int NCH = 3;

  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2
  } chan_e;

  // processing order: green, blue, red
  function automatic chan_e step_to_chan(logic [1:0] step);
    case (step)
      2'd0:    return CH_GREEN;
      2'd1:    return CH_BLUE;
      default: return CH_RED;
    endcase
  endfunction
endpackage

// File: rtl/cm_premask.sv
module cm_premask #(
  parameter int W       = 32,
  parameter int DEPTH_W = 6
) (
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [W-1:0]       premask_o
);
  localparam int UW = DEPTH_W - 3;

  logic [UW-1:0] unit;
  int            lim;

  always_comb begin
    unit = depth_i[DEPTH_W-1:3];
    case (unit)
      UW'(2):         lim = 16;
      UW'(3), UW'(4): lim = 24;
      default:        lim = 0;
    endcase
    for (int i = 0; i < W; i++) premask_o[i] = (i < lim);
  end
endmodule

// File: rtl/cm_bit_scan.sv
module cm_bit_scan #(
  parameter int W  = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  output logic [SW-1:0] lo_o,
  output logic [SW-1:0] hi_o,
  output logic          zero_o
);
  // forward scan: last hit walking down is the lowest set bit
  always_comb begin
    lo_o = '0;
    for (int i = W - 1; i >= 0; i--) if (val_i[i]) lo_o = SW'(i);
  end

  // reverse scan: last hit walking up is the highest set bit
  always_comb begin
    hi_o = '0;
    for (int i = 0; i < W; i++) if (val_i[i]) hi_o = SW'(i);
  end

  assign zero_o = ~|val_i;
endmodule

// File: rtl/cm_field_calc.sv
module cm_field_calc #(
  parameter int W      = 32,
  parameter int COMP_W = 8,
  localparam int SW = $clog2(W),
  localparam int BW = SW + 1,
  localparam int DW = $clog2(COMP_W)
) (
  input  logic [SW-1:0] lo_i,
  input  logic [SW-1:0] hi_i,
  input  logic          zero_i,
  output logic [SW-1:0] up_o,
  output logic [DW-1:0] down_o,
  output logic [BW-1:0] bits_o
);
  logic [BW-1:0] width;

  always_comb begin
    width = {1'b0, hi_i} - {1'b0, lo_i} + BW'(1);
    if (zero_i) begin
      up_o   = '0;
      down_o = '0;
      bits_o = '0;
    end else begin
      up_o   = lo_i;
      bits_o = {1'b0, hi_i} + BW'(1);
      if (int'(width) >= COMP_W) down_o = '0;
      else                       down_o = DW'(COMP_W - int'(width));
    end
  end
endmodule

// File: rtl/chan_mask_analyzer.sv
module chan_mask_analyzer
  import cm_pkg::*;
#(
  parameter int W       = 32,
  parameter int DEPTH_W = 6,
  parameter int COMP_W  = 8,
  localparam int SW = $clog2(W),
  localparam int BW = SW + 1,
  localparam int DW = $clog2(COMP_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [DEPTH_W-1:0]   depth_i,
  input  logic [W-1:0]         mask_r_i,
  input  logic [W-1:0]         mask_g_i,
  input  logic [W-1:0]         mask_b_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 fail_o,
  output logic [NCH*W-1:0]     qmask_o,
  output logic [NCH*SW-1:0]    up_o,
  output logic [NCH*DW-1:0]    down_o,
  output logic [NCH*BW-1:0]    bits_o,
  output logic [NCH-1:0]       zero_o
);
  localparam logic [1:0] LAST_STEP = 2'(NCH - 1);

  logic [W-1:0]                pm_now, pm_q;
  logic [NCH-1:0][W-1:0]       raw_q;
  logic                        busy_q, done_q, fail_q;
  logic [1:0]                  step_q;
  chan_e                       sel;
  logic [W-1:0]                cur;
  logic [SW-1:0]               lo_s, hi_s;
  logic                        zero_s;
  logic [SW-1:0]               up_s;
  logic [DW-1:0]               down_s;
  logic [BW-1:0]               bits_s;

  logic [NCH-1:0][W-1:0]       q_q;
  logic [NCH-1:0][SW-1:0]      up_q;
  logic [NCH-1:0][DW-1:0]      down_q;
  logic [NCH-1:0][BW-1:0]      bits_q;
  logic [NCH-1:0]              zero_q;

  cm_premask #(.W(W), .DEPTH_W(DEPTH_W)) u_premask (
    .depth_i   (depth_i),
    .premask_o (pm_now)
  );

  assign sel = step_to_chan(step_q);
  assign cur = raw_q[sel] & pm_q;

  cm_bit_scan #(.W(W)) u_scan (
    .val_i  (cur),
    .lo_o   (lo_s),
    .hi_o   (hi_s),
    .zero_o (zero_s)
  );

  cm_field_calc #(.W(W), .COMP_W(COMP_W)) u_calc (
    .lo_i   (lo_s),
    .hi_i   (hi_s),
    .zero_i (zero_s),
    .up_o   (up_s),
    .down_o (down_s),
    .bits_o (bits_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      step_q <= '0;
      pm_q   <= '0;
      raw_q  <= '0;
      q_q    <= '0;
      up_q   <= '0;
      down_q <= '0;
      bits_q <= '0;
      zero_q <= '0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      if (busy_q) begin
        q_q[sel]    <= cur;
        up_q[sel]   <= up_s;
        down_q[sel] <= down_s;
        bits_q[sel] <= bits_s;
        zero_q[sel] <= zero_s;
        if (step_q == LAST_STEP) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 2'd1;
        end
      end else if (start_i) begin
        if (pm_now == '0) begin
          done_q <= 1'b1;
          fail_q <= 1'b1;
        end else begin
          busy_q          <= 1'b1;
          step_q          <= '0;
          pm_q            <= pm_now;
          raw_q[CH_RED]   <= mask_r_i;
          raw_q[CH_GREEN] <= mask_g_i;
          raw_q[CH_BLUE]  <= mask_b_i;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign fail_o  = fail_q;
  assign qmask_o = q_q;
  assign up_o    = up_q;
  assign down_o  = down_q;
  assign bits_o  = bits_q;
  assign zero_o  = zero_q;

  // R9: completion is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9: the red write ends the run with done
  p_last_step_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && step_q == LAST_STEP) |=> (done_o && !busy_o && !fail_o));

  // R3: fail only with done, and never while busy
  p_fail_with_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (done_o && !busy_o));

  // R3: a rejected depth leaves results untouched
  p_fail_keeps_results_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> ($stable(qmask_o) && $stable(up_o) && $stable(bits_o) && $stable(zero_o)));

  // R10: captured operands hold while a run is in flight
  p_ignore_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> ($stable(raw_q) && $stable(pm_q)));

  // R7: an empty value forces both scan indices to zero
  p_zero_scan_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_s |-> (lo_s == '0 && hi_s == '0));

  // R4: forward and reverse scans never cross on a nonzero value
  p_scan_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zero_s |-> (lo_s <= hi_s && cur[lo_s] && cur[hi_s]));
endmodule

// File: tb/chan_mask_analyzer_bench.sv
`timescale 1ns/1ps
module chan_mask_analyzer_bench;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  depth = '0;
  logic [31:0] m_r = '0, m_g = '0, m_b = '0;
  logic        busy, done, fail;
  logic [95:0] qmask;
  logic [14:0] up;
  logic [8:0]  down;
  logic [17:0] bits;
  logic [2:0]  zero;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // expected state of the result registers, index 0 red, 1 green, 2 blue
  logic [31:0] e_q[3];
  logic [4:0]  e_up[3];
  logic [2:0]  e_dn[3];
  logic [5:0]  e_bits[3];
  logic        e_z[3];

  always #5 clk = ~clk;

  chan_mask_analyzer u_chan_mask_analyzer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .depth_i(depth),
    .mask_r_i(m_r), .mask_g_i(m_g), .mask_b_i(m_b),
    .busy_o(busy), .done_o(done), .fail_o(fail),
    .qmask_o(qmask), .up_o(up), .down_o(down), .bits_o(bits), .zero_o(zero)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_premask(logic [5:0] d);
    int lim;
    logic [31:0] m;
    case (d / 8)
      2:       lim = 16;
      3, 4:    lim = 24;
      default: lim = 0;
    endcase
    m = '0;
    for (int i = 0; i < lim; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic ref_chan(input logic [31:0] q, output logic [4:0] u,
                          output logic [2:0] dn, output logic [5:0] b, output logic z);
    int lo, hi, wd;
    lo = -1; hi = -1;
    for (int i = 0; i < 32; i++) if (q[i]) begin
      if (lo < 0) lo = i;
      hi = i;
    end
    if (lo < 0) begin
      u = 0; dn = 0; b = 0; z = 1;
    end else begin
      wd = hi - lo + 1;
      u = 5'(lo); b = 6'(hi + 1); z = 0;
      dn = (wd >= 8) ? 3'd0 : 3'(8 - wd);
    end
  endtask

  task automatic chk_chan(int c, logic [31:0] q, logic [4:0] u, logic [2:0] dn,
                          logic [5:0] b, logic z);
    chk("R2 qualified mask", qmask[c*32 +: 32], q);
    chk("R4 up-shift",       up[c*5 +: 5],      u);
    chk("R5 down-shift",     down[c*3 +: 3],    dn);
    chk("R6 bit count",      bits[c*6 +: 6],    b);
    chk("R7 zero flag",      zero[c],           z);
  endtask

  task automatic chk_all_model();
    for (int c = 0; c < 3; c++) chk_chan(c, e_q[c], e_up[c], e_dn[c], e_bits[c], e_z[c]);
  endtask

  // one request; poke re-asserts start with junk during the first busy cycle
  task automatic run(logic [5:0] d, logic [31:0] r, logic [31:0] g, logic [31:0] bl,
                     bit check_order, bit poke);
    logic [31:0] pm, nq[3];
    logic [4:0]  nu[3];
    logic [2:0]  nd[3];
    logic [5:0]  nb[3];
    logic        nz[3];
    pm = ref_premask(d);
    nq[0] = r & pm; nq[1] = g & pm; nq[2] = bl & pm;
    for (int c = 0; c < 3; c++) ref_chan(nq[c], nu[c], nd[c], nb[c], nz[c]);

    @(negedge clk);
    depth = d; m_r = r; m_g = g; m_b = bl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (pm == '0) begin
      chk("R3 done on bad depth", done, 1'b1);
      chk("R3 fail on bad depth", fail, 1'b1);
      chk("R3 busy stays low",    busy, 1'b0);
      chk_all_model();
      @(negedge clk);
      chk("R3 done pulse ends", done, 1'b0);
      return;
    end
    chk("R9 busy after accept", busy, 1'b1);
    chk("R9 no early done",     done, 1'b0);
    if (poke) begin
      depth = 6'd0; m_r = ~r; m_g = ~g; m_b = ~bl; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    if (check_order) begin
      chk_chan(1, nq[1], nu[1], nd[1], nb[1], nz[1]);
      chk("R8 blue not yet", qmask[64 +: 32], e_q[2]);
      chk("R8 red not yet",  qmask[0 +: 32],  e_q[0]);
    end
    @(negedge clk);
    if (check_order) begin
      chk_chan(2, nq[2], nu[2], nd[2], nb[2], nz[2]);
      chk("R8 red still old", qmask[0 +: 32], e_q[0]);
      chk("R9 busy mid run",  busy, 1'b1);
    end
    @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      e_q[c] = nq[c]; e_up[c] = nu[c]; e_dn[c] = nd[c]; e_bits[c] = nb[c]; e_z[c] = nz[c];
    end
    chk("R9 done at red write", done, 1'b1);
    chk("R9 fail low",          fail, 1'b0);
    chk("R9 busy cleared",      busy, 1'b0);
    chk_all_model();
    @(negedge clk);
    chk("R9 done one cycle", done, 1'b0);
    if (poke) begin
      chk("R10 no second run", busy, 1'b0);
      chk_all_model();
    end
  endtask

  initial begin
    for (int c = 0; c < 3; c++) begin
      e_q[c] = '0; e_up[c] = '0; e_dn[c] = '0; e_bits[c] = '0; e_z[c] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 fail", fail, 1'b0);
    chk("R1 qmask", qmask, 96'd0);
    chk("R1 up", up, 15'd0);
    chk("R1 down", down, 9'd0);
    chk("R1 bits", bits, 18'd0);
    chk("R1 zero", zero, 3'd0);
    rst_n = 1'b1;

    // R11 5:6:5 layout at 16 bits, with ordering observed
    run(6'd16, 32'h0000_F800, 32'h0000_07E0, 32'h0000_001F, 1, 0);
    chk("R11 red up",    up[0 +: 5],  5'd11);
    chk("R11 green up",  up[5 +: 5],  5'd5);
    chk("R11 blue up",   up[10 +: 5], 5'd0);
    chk("R11 red down",  down[0 +: 3], 3'd3);
    chk("R11 green down",down[3 +: 3], 3'd2);
    chk("R11 blue down", down[6 +: 3], 3'd3);

    // R7 zero masks, raw zero and zero after premask
    run(6'd16, 32'h0000_0000, 32'h00FF_0000, 32'h0000_0034, 1, 0);
    chk("R6 0x34 needs 6 bits", bits[12 +: 6], 6'd6);

    // R10 start while busy is ignored
    run(6'd24, 32'h00F0_0000, 32'h0000_3C00, 32'h0000_0007, 1, 1);

    // R3 failure leaves results as they were
    run(6'd8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);

    // R2 / R3 full depth sweep
    for (int d = 0; d < 64; d++)
      run(6'(d), 32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h0F0F_0000, 0, 0);

    // R4 R5 R6 every contiguous field, placed in rotating channels
    for (int lo = 0; lo < 32; lo++)
      for (int hi = lo; hi < 32; hi++) begin
        logic [31:0] f;
        f = '0;
        for (int i = lo; i <= hi; i++) f[i] = 1'b1;
        run(6'd32, f, {f[15:0], f[31:16]}, f & 32'h0000_FF00, (lo == hi), 0);
      end

    // sparse, non-contiguous patterns
    for (int k = 0; k < 40; k++) begin
      logic [31:0] a;
      a = 32'h9E37_79B9 * (k + 1);
      run(6'd24 + 6'(k % 16), a, a ^ 32'h8000_0001, a & (a >> 3), 0, (k % 7) == 0);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule